// File: doc/BRIEF.md
# Floating-Point Condition Comparator

This block compares two IEEE-754 single-precision values and reduces the comparison to one boolean according to a 4-bit condition selector. It is purely combinational. An execution unit that already applies any operand negation or absolute value places the two values at the inputs and reads the answer in the same cycle. It also combines the answer with predicates or writes it back.

The selector covers six classes of test. Two are constants, always false and always true. Six relational tests discard the result when a NaN is present. The same six relations come a second time in forms that also pass when a NaN is present. The last two tests ask whether both inputs are numbers or whether at least one is a NaN. An optional flush control makes subnormal inputs behave as zeros of the same sign before the comparison. The results are exact for zeros of either sign, for infinities and for NaNs.

Top module: `fpcc_compare`

## Requirements
- R1: Selector 0 yields 0 and selector 15 yields 1, for any operands and any flush setting.
- R2: Selectors 1 to 6 give the ordered relations a<b, a==b, a<=b, a>b, a!=b and a>=b, in that order. Each of them yields 0 whenever either operand is a NaN.
- R3: Selectors 9 to 14 give the same six relations in the same order. Each of them yields 1 whenever either operand is a NaN, and otherwise yields the relation itself.
- R4: Selector 7 yields 1 exactly when neither operand is a NaN. Selector 8 yields 1 exactly when at least one operand is a NaN.
- R5: A NaN is any value whose exponent field (bits 30:23) is all ones and whose mantissa field (bits 22:0) is nonzero. Infinities, with a zero mantissa and either sign, are ordered values: they are larger or smaller than every finite value and equal to an infinity of the same sign.
- R6: +0 (0x00000000) and -0 (0x80000000) compare equal, so ordered a!=b on the two of them is 0 and a<b is 0.
- R7: Values that are not NaNs are ordered by sign and magnitude. Any negative value that is not a zero is below any positive value. Among negative values the one with the larger magnitude is the smaller value.
- R8: With flush_en = 1, an operand whose exponent field is zero compares as a zero of its own sign. With flush_en = 0, subnormal values compare by their true value. Normal values are never altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand, single precision |
| opnd_b | input | 32 | Second operand, single precision |
| cond_sel | input | 4 | Condition selector, codes 0 to 15 |
| flush_en | input | 1 | Treat subnormal inputs as signed zero |
| result | output | 1 | Boolean outcome of the selected test |

## Verification
The immediate assertions assume the two operands and the selector are settled, known values whenever the combinational logic evaluates. A transient half-updated operand could make the relational flags briefly disagree. The bench therefore changes every input together on the falling clock edge and reads the result only after a full half period. The vectors cover each class of encoding the assertions reason about: quiet and signalling NaNs of both signs, both infinities, both zeros, and subnormals just below the smallest normal, each with and without flush. This keeps the assertions' mutual-exclusion and signed-zero premises exercised on legal encodings only.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Condition selector values; bit 3 marks "NaN passes",
    // bits 2:0 are a mask over {greater, equal, less}.
    typedef enum logic [3:0] {
        CC_FALSE = 4'd0,
        CC_LT    = 4'd1,
        CC_EQ    = 4'd2,
        CC_LE    = 4'd3,
        CC_GT    = 4'd4,
        CC_NE    = 4'd5,
        CC_GE    = 4'd6,
        CC_NUM   = 4'd7,
        CC_NAN   = 4'd8,
        CC_LTU   = 4'd9,
        CC_EQU   = 4'd10,
        CC_LEU   = 4'd11,
        CC_GTU   = 4'd12,
        CC_NEU   = 4'd13,
        CC_GEU   = 4'd14,
        CC_TRUE  = 4'd15
    } cc_code_e;

    // Classification of one operand after optional flush.
    typedef struct packed {
        logic sign;
        logic nan;
        logic zero;
    } fp_tag_t;

    // Relation between the two operands.
    typedef struct packed {
        logic unord;
        logic gt;
        logic eq;
        logic lt;
    } fp_rel_t;

    function automatic logic select_outcome(input logic [3:0] code, input fp_rel_t rel);
        logic hit;
        hit = |(code[2:0] & {rel.gt, rel.eq, rel.lt});
        return (hit & ~rel.unord) | (code[3] & rel.unord);
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]   value,
    input  logic                   flush,
    output fp_tag_t                tag,
    output logic [EXP_W+MAN_W-1:0] mag
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             exp_min;

    assign exp_f   = value[MAG_W-1:MAN_W];
    assign man_f   = value[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;

    always_comb begin
        mag      = (flush && exp_min) ? '0 : value[MAG_W-1:0];
        tag.sign = value[MAG_W];
        tag.nan  = exp_max && (man_f != '0);
        tag.zero = (mag == '0);
    end

    always_comb begin
        if (flush && (value[MAG_W-1:MAN_W] == '0))
            AST_FLUSH_ZERO: assert (tag.zero && !tag.nan); // R8
        if (value[MAG_W-1:MAN_W] != '0)
            AST_NORMAL_KEPT: assert (mag == value[MAG_W-1:0]); // R8
    end

endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fp_tag_t          tag_a,
    input  fp_tag_t          tag_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output fp_rel_t          rel
);
    logic both_zero;
    logic mag_less;
    logic mag_same;

    assign both_zero = tag_a.zero && tag_b.zero;
    assign mag_less  = mag_a < mag_b;
    assign mag_same  = mag_a == mag_b;

    always_comb begin
        rel       = '0;
        rel.unord = tag_a.nan || tag_b.nan;
        if (both_zero) begin
            rel.eq = 1'b1;
        end else if (tag_a.sign != tag_b.sign) begin
            rel.lt = tag_a.sign;
            rel.gt = tag_b.sign;
        end else if (mag_same) begin
            rel.eq = 1'b1;
        end else begin
            rel.lt = tag_a.sign ? !mag_less : mag_less;
            rel.gt = tag_a.sign ? mag_less : !mag_less;
        end
    end

    always_comb begin
        if (!rel.unord)
            AST_ONE_RELATION: assert ($countones({rel.lt, rel.eq, rel.gt}) == 1); // R7
        if (tag_a.zero && tag_b.zero)
            AST_ZERO_SIGN_EQ: assert (rel.eq && !rel.lt && !rel.gt); // R6
        if (!rel.unord && (tag_a.sign != tag_b.sign) && !both_zero)
            AST_SIGN_ORDER: assert (rel.lt == tag_a.sign); // R7
    end

endmodule

// File: rtl/fpcc_compare.sv
module fpcc_compare
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] opnd_a,
    input  logic [EXP_W+MAN_W:0] opnd_b,
    input  logic [3:0]           cond_sel,
    input  logic                 flush_en,
    output logic                 result
);
    localparam int MAG_W = EXP_W + MAN_W;
    localparam int NOPS  = 2;

    logic [MAG_W:0]   op_in  [NOPS];
    fp_tag_t          op_tag [NOPS];
    logic [MAG_W-1:0] op_mag [NOPS];
    fp_rel_t          rel;

    assign op_in[0] = opnd_a;
    assign op_in[1] = opnd_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fpcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .value (op_in[i]),
            .flush (flush_en),
            .tag   (op_tag[i]),
            .mag   (op_mag[i])
        );
    end

    fpcmp_relate #(
        .MAG_W (MAG_W)
    ) u_rel (
        .tag_a (op_tag[0]),
        .tag_b (op_tag[1]),
        .mag_a (op_mag[0]),
        .mag_b (op_mag[1]),
        .rel   (rel)
    );

    assign result = select_outcome(cond_sel, rel);

    always_comb begin
        if (cond_sel == CC_FALSE)
            AST_CONST_LOW: assert (!result); // R1
        if (cond_sel == CC_TRUE)
            AST_CONST_HIGH: assert (result); // R1
        if (rel.unord && !cond_sel[3])
            AST_ORDERED_NAN: assert (!result); // R2
        if (rel.unord && cond_sel[3])
            AST_UNORDERED_NAN: assert (result); // R3
        if (cond_sel == CC_NUM)
            AST_NUM_TEST: assert (result == !(op_tag[0].nan || op_tag[1].nan)); // R4
        if (cond_sel == CC_NAN)
            AST_NAN_TEST: assert (result == (op_tag[0].nan || op_tag[1].nan)); // R4
    end

endmodule

// File: tb/fpcc_compare_bench.sv
module fpcc_compare_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  cond_sel = '0;
    logic        flush_en = 1'b0;
    logic        result;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fpcc_compare u_fpcc_compare (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .cond_sel (cond_sel),
        .flush_en (flush_en),
        .result   (result)
    );

    // Fields: a, b, selector, flush, expected, requirement number
    localparam int NV = 41;
    localparam logic [73:0] VEC [NV] = '{
        {32'h3F800000, 32'h40000000, 4'd1,  1'b0, 1'b1, 4'd2}, // R2 1<2
        {32'h40000000, 32'h3F800000, 4'd1,  1'b0, 1'b0, 4'd2}, // R2
        {32'h3F800000, 32'h3F800000, 4'd2,  1'b0, 1'b1, 4'd2}, // R2
        {32'h3F800000, 32'h40000000, 4'd3,  1'b0, 1'b1, 4'd2}, // R2
        {32'h40000000, 32'h3F800000, 4'd4,  1'b0, 1'b1, 4'd2}, // R2
        {32'h3F800000, 32'h40000000, 4'd5,  1'b0, 1'b1, 4'd2}, // R2
        {32'h3F800000, 32'h3F800000, 4'd6,  1'b0, 1'b1, 4'd2}, // R2
        {32'h7FC00000, 32'h3F800000, 4'd1,  1'b0, 1'b0, 4'd2}, // R2 NaN
        {32'h3F800000, 32'h7FC00000, 4'd5,  1'b0, 1'b0, 4'd2}, // R2 NaN
        {32'hBF800000, 32'hC0000000, 4'd1,  1'b0, 1'b0, 4'd7}, // R7 -1<-2
        {32'hC0000000, 32'hBF800000, 4'd1,  1'b0, 1'b1, 4'd7}, // R7
        {32'hBF800000, 32'h3F800000, 4'd1,  1'b0, 1'b1, 4'd7}, // R7
        {32'h3F800000, 32'hBF800000, 4'd4,  1'b0, 1'b1, 4'd7}, // R7
        {32'h00000000, 32'h80000000, 4'd2,  1'b0, 1'b1, 4'd6}, // R6
        {32'h00000000, 32'h80000000, 4'd5,  1'b0, 1'b0, 4'd6}, // R6
        {32'h80000000, 32'h00000000, 4'd1,  1'b0, 1'b0, 4'd6}, // R6
        {32'h7FC00000, 32'h3F800000, 4'd9,  1'b0, 1'b1, 4'd3}, // R3
        {32'h40000000, 32'h3F800000, 4'd9,  1'b0, 1'b0, 4'd3}, // R3
        {32'h3F800000, 32'h40000000, 4'd9,  1'b0, 1'b1, 4'd3}, // R3
        {32'h7FC00000, 32'h7FC00000, 4'd10, 1'b0, 1'b1, 4'd3}, // R3
        {32'h3F800000, 32'h3F800000, 4'd13, 1'b0, 1'b0, 4'd3}, // R3
        {32'h40000000, 32'h3F800000, 4'd12, 1'b0, 1'b1, 4'd3}, // R3
        {32'h3F800000, 32'h40000000, 4'd7,  1'b0, 1'b1, 4'd4}, // R4
        {32'h7FC00000, 32'h3F800000, 4'd7,  1'b0, 1'b0, 4'd4}, // R4
        {32'h3F800000, 32'h7F800001, 4'd8,  1'b0, 1'b1, 4'd4}, // R4
        {32'h3F800000, 32'h40000000, 4'd8,  1'b0, 1'b0, 4'd4}, // R4
        {32'h7FC00000, 32'h7FC00000, 4'd0,  1'b0, 1'b0, 4'd1}, // R1
        {32'h7FC00000, 32'h3F800000, 4'd15, 1'b1, 1'b1, 4'd1}, // R1
        {32'h3F800000, 32'h3F800000, 4'd0,  1'b1, 1'b0, 4'd1}, // R1
        {32'h3F800000, 32'h40000000, 4'd15, 1'b0, 1'b1, 4'd1}, // R1
        {32'h7F800000, 32'h7F7FFFFF, 4'd4,  1'b0, 1'b1, 4'd5}, // R5 inf
        {32'hFF800000, 32'hFF800000, 4'd2,  1'b0, 1'b1, 4'd5}, // R5
        {32'h7F800000, 32'h7F800001, 4'd6,  1'b0, 1'b0, 4'd5}, // R5 sNaN
        {32'hFF800001, 32'hFF800000, 4'd1,  1'b0, 1'b0, 4'd5}, // R5 -NaN
        {32'h00000001, 32'h00000000, 4'd4,  1'b0, 1'b1, 4'd8}, // R8
        {32'h00000001, 32'h00000000, 4'd4,  1'b1, 1'b0, 4'd8}, // R8 flushed
        {32'h00000001, 32'h00000000, 4'd2,  1'b1, 1'b1, 4'd8}, // R8
        {32'h80000001, 32'h00000001, 4'd1,  1'b0, 1'b1, 4'd8}, // R8
        {32'h80000001, 32'h00000001, 4'd1,  1'b1, 1'b0, 4'd8}, // R8
        {32'h007FFFFF, 32'h00800000, 4'd1,  1'b1, 1'b1, 4'd8}, // R8 normal kept
        {32'h00800000, 32'h007FFFFF, 4'd4,  1'b1, 1'b1, 4'd8}  // R8
    };

    task automatic apply_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [3:0] sel, input logic fl,
                               input logic exp, input int req);
        @(negedge clk);
        opnd_a   = a;
        opnd_b   = b;
        cond_sel = sel;
        flush_en = fl;
        @(posedge clk);
        #1;
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL R%0d a=%h b=%h sel=%0d flush=%0b actual=%0b expected=%0b",
                     req, a, b, sel, fl, result, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: all-zero inputs with selector 0 give 0 (R1)
        #1;
        checks++;
        if (result !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b expected=0", result);
        end

        for (int i = 0; i < NV; i++)
            apply_check(VEC[i][73:42], VEC[i][41:10], VEC[i][9:6],
                        VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));

        // Sweeps over all selectors. a<b: odd codes pass (R2, R3)
        for (int c = 0; c < 16; c++)
            apply_check(32'hC0000000, 32'h3F800000, c[3:0], 1'b0, 16'hAAAA >> c, 2);
        // a==b (-0 vs +0 after flush of -denormal): codes 2,3,6,7,10,11,14,15 (R6)
        for (int c = 0; c < 16; c++)
            apply_check(32'h80000005, 32'h00000000, c[3:0], 1'b1, 16'hCCCC >> c, 6);
        // a>b with infinities: codes 4,5,6,7,12,13,14,15 (R5)
        for (int c = 0; c < 16; c++)
            apply_check(32'h7F800000, 32'hFF800000, c[3:0], 1'b0, 16'hF0F0 >> c, 5);
        // Any NaN: codes 8..15 pass, 0..7 fail (R3, R4)
        for (int c = 0; c < 16; c++)
            apply_check(32'h3F800000, 32'hFFC00000, c[3:0], 1'b0, c >= 8, 3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule